// File: doc/BRIEF.md
# Raise/Acknowledge Interrupt Status Controller

This block is the interrupt source of a memory-mapped peripheral. It keeps a 32-bit word of pending interrupt causes. Software adds causes by writing a raise register. Engines inside the peripheral add causes through a per-bit request port. Software removes causes by writing an acknowledge register, and the status word itself can only be read. No other path sets or clears a status bit.

The interrupt leaves the block in one of two forms, and a static mode input selects the form. In line mode, which is the mode a system uses after reset with the mode input low, a level output stays high while any cause is pending. In message mode the level output stays low. A one-cycle pulse marks each cycle in which at least one cause becomes newly pending. The handler writes the acknowledge register in both modes, because pending bits never clear themselves.

The register port is a simple single-cycle request bus. A read returns its data one cycle later with a valid strobe. All offsets are byte addresses of 32-bit words.

Top module: `irqc_raise_ack`

## Requirements
- R1: After reset the status word is zero, `irq_level` is 0, `irq_msg` is 0 and `bus_rvalid` is 0.
- R2: A write to offset 0x60 ORs the write data into the status word. A read of offset 0x24 returns the status word, with `bus_rvalid` high in the cycle after the read request.
- R3: A write to offset 0x64 clears exactly the status bits that are 1 in the write data. All other bits keep their value.
- R4: A pending status bit stays set until it is acknowledged, in both modes, when no raise, acknowledge or set request is made.
- R5: With `msg_mode` = 0, `irq_level` is 1 exactly when the status word is non-zero. With `msg_mode` = 1, `irq_level` is 0.
- R6: With `msg_mode` = 1, a change of the status word from zero to non-zero makes `irq_msg` high for exactly one cycle. That cycle is the first cycle in which the new status is visible.
- R7: With `msg_mode` = 1, setting a bit that was clear while other bits are pending makes a one-cycle `irq_msg` pulse. Raising only bits that are already set makes no pulse. With `msg_mode` = 0, `irq_msg` stays 0.
- R8: A 1 on bit i of `set_req` in a cycle sets status bit i on the next clock edge. This is combined by OR with any raise write in the same cycle.
- R9: If `set_req` and an acknowledge write name the same bit in the same cycle, that bit ends up set.
- R10: Reads of offsets 0x60 and 0x64 return zero. A write to offset 0x24 leaves the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronised inside the block. |
| bus_sel | input | 1 | Register request valid for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid when `bus_rvalid` is high |
| bus_rvalid | output | 1 | Read data strobe, one cycle after a read request |
| set_req | input | DATA_W (32) | Per-bit set requests from internal engines |
| msg_mode | input | 1 | 0 = level line, 1 = one-shot message pulse |
| irq_level | output | 1 | Level interrupt line |
| irq_msg | output | 1 | One-cycle message interrupt pulse |

## Verification
The assertions assume that `msg_mode` is quasi-static, that is, it does not change in the same cycle as a status update it would have to judge. They also assume that each bus request lasts one cycle and names one register. The bench changes the mode only while the bus is idle and no set requests are made. It issues every access as a single-cycle request driven on the falling edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Register byte offsets that software decodes
  localparam int unsigned OFS_STATUS = 32'h24;
  localparam int unsigned OFS_RAISE  = 32'h60;
  localparam int unsigned OFS_ACK    = 32'h64;

  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_STATUS = 2'd1,
    ACC_RAISE  = 2'd2,
    ACC_ACK    = 2'd3
  } acc_e;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] raise_bits,
  output logic [DATA_W-1:0] ack_bits,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_RAISE  = ADDR_W'(OFS_RAISE);
  localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(OFS_ACK);

  acc_e              acc;
  logic              wr_en;
  logic              rd_en;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  always_comb begin
    if (bus_addr == A_STATUS)     acc = ACC_STATUS;
    else if (bus_addr == A_RAISE) acc = ACC_RAISE;
    else if (bus_addr == A_ACK)   acc = ACC_ACK;
    else                          acc = ACC_NONE;
  end

  always_comb begin
    wr_en      = bus_sel && bus_wr;
    rd_en      = bus_sel && !bus_wr;
    raise_bits = (wr_en && acc == ACC_RAISE) ? bus_wdata : '0;
    ack_bits   = (wr_en && acc == ACC_ACK)   ? bus_wdata : '0;
    // write-only and unmapped offsets read as zero
    rdata_d    = (acc == ACC_STATUS) ? status_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (bus_addr == A_RAISE || bus_addr == A_ACK)) |=> (bus_rvalid && bus_rdata == '0)); // R10
  AST_READ_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> bus_rvalid); // R2
endmodule

// File: rtl/irqc_status.sv
module irqc_status #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] raise_bits,
  input  logic [DATA_W-1:0] ack_bits,
  input  logic [DATA_W-1:0] set_req,
  output logic [DATA_W-1:0] status_d,
  output logic [DATA_W-1:0] status_q
);
  logic [DATA_W-1:0] set_bits;
  logic              upd_en;
  logic [DATA_W-1:0] stat_r;

  always_comb begin
    set_bits = raise_bits | set_req;
    upd_en   = (|set_bits) || (|ack_bits);
    // set has priority over clear on the same bit
    status_d = (stat_r & ~ack_bits) | set_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stat_r <= '0;
    else if (upd_en) stat_r <= status_d;
  end

  assign status_q = stat_r;

  AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_bits != '0) |=> ((status_q & $past(raise_bits)) == $past(raise_bits))); // R2
  AST_SETREQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req != '0) |=> ((status_q & $past(set_req)) == $past(set_req))); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_bits != '0 && raise_bits == '0 && set_req == '0) |=> ((status_q & $past(ack_bits)) == '0)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_bits == '0 && ack_bits == '0 && set_req == '0) |=> $stable(status_q)); // R4
  AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_req & ack_bits) != '0) |=> ((status_q & $past(set_req & ack_bits)) == $past(set_req & ack_bits))); // R9
endmodule

// File: rtl/irqc_notify.sv
module irqc_notify #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_mode,
  input  logic [DATA_W-1:0] status_d,
  input  logic [DATA_W-1:0] status_q,
  output logic              irq_level,
  output logic              irq_msg
);
  logic [DATA_W-1:0] rising;
  logic              pulse_d;
  logic              pulse_q;

  always_comb begin
    rising    = status_d & ~status_q;
    pulse_d   = msg_mode && (|rising);
    irq_level = (|status_q) && !msg_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign irq_msg = pulse_q;

  AST_MSG_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_msg |-> (status_q != '0)); // R7
  AST_MSG_ONLY_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_msg |-> $past(msg_mode)); // R7
  AST_LEVEL_OFF_IN_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    msg_mode |-> !irq_level); // R5
  AST_MSG_ON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_mode && status_q == '0 && status_d != '0) |=> irq_msg); // R6
endmodule

// File: rtl/irqc_raise_ack.sv
module irqc_raise_ack #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [DATA_W-1:0] set_req,
  input  logic              msg_mode,
  output logic              irq_level,
  output logic              irq_msg
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync;
  logic              rst_int_n;
  logic [DATA_W-1:0] raise_bits;
  logic [DATA_W-1:0] ack_bits;
  logic [DATA_W-1:0] status_d;
  logic [DATA_W-1:0] status_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync[SYNC_N-1];

  irqc_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .status_q   (status_q),
    .raise_bits (raise_bits),
    .ack_bits   (ack_bits),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid)
  );

  irqc_status #(.DATA_W(DATA_W)) u_status (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .raise_bits (raise_bits),
    .ack_bits   (ack_bits),
    .set_req    (set_req),
    .status_d   (status_d),
    .status_q   (status_q)
  );

  irqc_notify #(.DATA_W(DATA_W)) u_notify (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .msg_mode  (msg_mode),
    .status_d  (status_d),
    .status_q  (status_q),
    .irq_level (irq_level),
    .irq_msg   (irq_msg)
  );
endmodule

// File: tb/irqc_raise_ack_test.sv
`timescale 1ns/1ps
module irqc_raise_ack_test;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [AW-1:0] O_STAT  = 8'h24;
  localparam logic [AW-1:0] O_RAISE = 8'h60;
  localparam logic [AW-1:0] O_ACK   = 8'h64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel;
  logic          bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic          bus_rvalid;
  logic [DW-1:0] set_req;
  logic          msg_mode;
  logic          irq_level;
  logic          irq_msg;

  int total = 0;
  int bad   = 0;
  logic [DW-1:0] rd;

  always #5 clk = ~clk;

  irqc_raise_ack #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .set_req(set_req), .msg_mode(msg_mode),
    .irq_level(irq_level), .irq_msg(irq_msg)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    chk(bus_rvalid === 1'b1, "R2 rvalid", {31'b0, bus_rvalid}, 32'h1);
    d = bus_rdata;
  endtask

  task automatic clear_all();
    bus_write(O_ACK, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    chk(irq_level === 1'b0, "R1 level", {31'b0, irq_level}, 0);
    chk(irq_msg === 1'b0, "R1 msg", {31'b0, irq_msg}, 0);
    chk(bus_rvalid === 1'b0, "R1 rvalid", {31'b0, bus_rvalid}, 0);
    bus_read(O_STAT, rd);
    chk(rd === 32'h0, "R1 status", rd, 0);
  endtask

  task automatic t_raise();
    bus_write(O_RAISE, 32'h0000_0011);
    bus_write(O_RAISE, 32'h8000_0100);
    bus_read(O_STAT, rd);
    chk(rd === 32'h8000_0111, "R2 or-in", rd, 32'h8000_0111);
    chk(irq_level === 1'b1, "R5 level on", {31'b0, irq_level}, 1);
  endtask

  task automatic t_ack();
    bus_write(O_ACK, 32'h8000_0010);
    bus_read(O_STAT, rd);
    chk(rd === 32'h0000_0101, "R3 partial ack", rd, 32'h101);
    repeat (5) @(negedge clk);
    bus_read(O_STAT, rd);
    chk(rd === 32'h0000_0101, "R4 held", rd, 32'h101);
    clear_all();
    bus_read(O_STAT, rd);
    chk(rd === 32'h0, "R3 full ack", rd, 0);
    chk(irq_level === 1'b0, "R5 level off", {31'b0, irq_level}, 0);
  endtask

  task automatic t_msg();
    msg_mode = 1'b1;
    @(negedge clk);
    bus_write(O_RAISE, 32'h0000_0004);
    chk(irq_msg === 1'b1, "R6 first pulse", {31'b0, irq_msg}, 1);
    chk(irq_level === 1'b0, "R5 level masked", {31'b0, irq_level}, 0);
    @(negedge clk);
    chk(irq_msg === 1'b0, "R6 one cycle", {31'b0, irq_msg}, 0);
    bus_write(O_RAISE, 32'h0000_0004);
    chk(irq_msg === 1'b0, "R7 repeat no pulse", {31'b0, irq_msg}, 0);
    bus_write(O_RAISE, 32'h0000_0044);
    chk(irq_msg === 1'b1, "R7 new bit pulse", {31'b0, irq_msg}, 1);
    repeat (4) @(negedge clk);
    bus_read(O_STAT, rd);
    chk(rd === 32'h0000_0044, "R4 held in msg mode", rd, 32'h44);
    clear_all();
    msg_mode = 1'b0;
    @(negedge clk);
    bus_write(O_RAISE, 32'h0000_0001);
    chk(irq_msg === 1'b0, "R7 no pulse in line mode", {31'b0, irq_msg}, 0);
    clear_all();
  endtask

  task automatic t_set_port();
    set_req = 32'h0000_0200;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = O_RAISE; bus_wdata = 32'h0000_0002;
    @(negedge clk);
    set_req = '0; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    bus_read(O_STAT, rd);
    chk(rd === 32'h0000_0202, "R8 set port", rd, 32'h202);
    // set and acknowledge on the same bits, one pending already
    set_req = 32'h0000_0201;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = O_ACK; bus_wdata = 32'h0000_0203;
    @(negedge clk);
    set_req = '0; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    bus_read(O_STAT, rd);
    chk(rd === 32'h0000_0201, "R9 set beats ack", rd, 32'h201);
    clear_all();
  endtask

  task automatic t_access_rules();
    bus_write(O_RAISE, 32'h0000_00F0);
    bus_read(O_RAISE, rd);
    chk(rd === 32'h0, "R10 raise reads zero", rd, 0);
    bus_read(O_ACK, rd);
    chk(rd === 32'h0, "R10 ack reads zero", rd, 0);
    bus_write(O_STAT, 32'h0000_0000);
    bus_write(O_STAT, 32'hFFFF_0000);
    bus_read(O_STAT, rd);
    chk(rd === 32'h0000_00F0, "R10 status write ignored", rd, 32'hF0);
    clear_all();
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; set_req = '0; msg_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_raise();
    t_ack();
    t_msg();
    t_set_port();
    t_access_rules();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule